// File: doc/BRIEF.md
# Five-Operation Integer ALU

This block is the combinational arithmetic and logic stage of a small RISC integer datapath. Two operands and a 3-bit operation code go in. A result and a zero flag come out in the same evaluation. The five operations are bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. No clock or state is involved.

Addition and subtraction share one grouped carry-lookahead adder. Subtraction adds the inverted second operand with a carry-in of one. Set-on-less-than reuses that difference: it combines the sign of the difference with the signed overflow, so the answer stays right near the ends of the range. A branch-on-equal in the surrounding datapath selects subtraction and tests the zero flag.

Top module: `alu_core`

## Requirements
- R1: Operation code 3'b000 drives `result` with the bitwise AND of `op_a` and `op_b`.
- R2: Operation code 3'b001 drives `result` with the bitwise OR of `op_a` and `op_b`.
- R3: Operation code 3'b010 drives `result` with `op_a + op_b`, modulo 2^WIDTH.
- R4: Operation code 3'b110 drives `result` with `op_a - op_b`, modulo 2^WIDTH.
- R5: Operation code 3'b111 drives `result[0]` with 1 when `op_a` is less than `op_b` as two's-complement numbers, and 0 otherwise. All bits above bit 0 are zero.
- R6: Set-on-less-than gives the correct signed answer even when the difference `op_a - op_b` overflows, for example most-negative against positive and most-positive against negative.
- R7: `zero` is 1 exactly when every bit of `result` is 0, for every operation code.
- R8: With operation code 3'b110, `zero` is 1 exactly when `op_a` equals `op_b`.
- R9: The unused operation codes 3'b011, 3'b100 and 3'b101 drive `result` to all zeros, so `zero` reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend for subtraction) |
| op_b | input | WIDTH | Second operand (subtrahend for subtraction) |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when `result` is all zeros |

## Verification
The assertions assume that the operands and the operation code are never unknown when they are evaluated; each check is skipped while any input is unknown. They also assume the inputs are settled, so each check reads a complete combinational evaluation. The bench drives every input to a known value and changes inputs only on the rising edge. It reads outputs only on the falling edge, well after the inputs have settled. It sweeps all eight operation codes, including the three unused ones, so every code the assertions accept is actually applied.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  // Codes with bit 2 set run the adder in subtract mode.
  function automatic logic op_subtracts(input logic [2:0] code);
    return code[2];
  endfunction

  // Signed less-than from the sign of the difference and the overflow.
  function automatic logic signed_less(input logic diff_sign, input logic diff_ovf);
    return diff_sign ^ diff_ovf;
  endfunction

  // Two's-complement overflow of x + y giving s, from the three sign bits.
  function automatic logic add_overflow(input logic x_msb, input logic y_msb,
                                        input logic s_msb);
    return (x_msb == y_msb) && (s_msb != x_msb);
  endfunction

endpackage

// File: rtl/alu_cla_group.sv
`timescale 1ns/1ps
module alu_cla_group #(
  parameter int GROUP = 4
) (
  input  logic [GROUP-1:0] x,
  input  logic [GROUP-1:0] y,
  input  logic             cin,
  output logic [GROUP-1:0] sum,
  output logic             grp_gen,
  output logic             grp_prop
);

  logic [GROUP-1:0] bit_gen;
  logic [GROUP-1:0] bit_prop;
  logic [GROUP:0]   carry;

  assign bit_gen  = x & y;
  assign bit_prop = x | y;

  // Carries inside the group.
  always_comb begin
    carry[0] = cin;
    for (int j = 0; j < GROUP; j++) begin
      carry[j+1] = bit_gen[j] | (bit_prop[j] & carry[j]);
    end
  end

  assign sum = x ^ y ^ carry[GROUP-1:0];

  // Group generate and propagate, for the lookahead stage above.
  always_comb begin
    grp_gen  = 1'b0;
    grp_prop = 1'b1;
    for (int j = 0; j < GROUP; j++) begin
      grp_gen  = bit_gen[j] | (bit_prop[j] & grp_gen);
      grp_prop = grp_prop & bit_prop[j];
    end
  end

endmodule

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
module alu_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);

  localparam int NGROUP = WIDTH / GROUP;

  logic [NGROUP-1:0] g_gen;
  logic [NGROUP-1:0] g_prop;
  logic [NGROUP:0]   g_carry;

  assign g_carry[0] = cin;

  for (genvar k = 0; k < NGROUP; k++) begin : g_grp
    alu_cla_group #(.GROUP(GROUP)) u_grp (
      .x        (x[k*GROUP +: GROUP]),
      .y        (y[k*GROUP +: GROUP]),
      .cin      (g_carry[k]),
      .sum      (sum[k*GROUP +: GROUP]),
      .grp_gen  (g_gen[k]),
      .grp_prop (g_prop[k])
    );
    assign g_carry[k+1] = g_gen[k] | (g_prop[k] & g_carry[k]);
  end

endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] and_out,
  output logic [WIDTH-1:0] or_out
);

  assign and_out = x & y;
  assign or_out  = x | y;

endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  // Named internal events, read by the bound checker.
  logic             sub_mode;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum_w;
  logic             sub_ovf;
  logic             lt_flag;
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;

  assign sub_mode = op_subtracts(op_sel);
  assign b_eff    = sub_mode ? ~op_b : op_b;

  alu_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_adder (
    .x   (op_a),
    .y   (b_eff),
    .cin (sub_mode),
    .sum (sum_w)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .x       (op_a),
    .y       (op_b),
    .and_out (and_w),
    .or_out  (or_w)
  );

  assign sub_ovf = add_overflow(op_a[MSB], b_eff[MSB], sum_w[MSB]);
  assign lt_flag = signed_less(sum_w[MSB], sub_ovf);

  always_comb begin
    case (op_sel)
      ALU_AND: result = and_w;
      ALU_OR:  result = or_w;
      ALU_ADD: result = sum_w;
      ALU_SUB: result = sum_w;
      ALU_SLT: result = {{(WIDTH-1){1'b0}}, lt_flag};
      default: result = '0;
    endcase
  end

  assign zero = ~|result;

endmodule

// File: rtl/alu_core_chk.sv
`timescale 1ns/1ps
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             sub_ovf
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!$isunknown({op_a, op_b, op_sel})) begin
      if (op_sel == 3'b000) begin
        assert_and_subset_R1: assert (((result & ~op_a) == '0) && ((result & ~op_b) == '0)
                                      && (((op_a & op_b) & ~result) == '0));
      end
      if (op_sel == 3'b001) begin
        assert_or_cover_R2: assert (((op_a & ~result) == '0) && ((op_b & ~result) == '0)
                                    && ((result & ~(op_a | op_b)) == '0));
      end
      if (op_sel == 3'b010) begin
        assert_add_undo_R3: assert (WIDTH'(result - op_b) == op_a);
      end
      if (op_sel == 3'b110) begin
        assert_sub_undo_R4: assert (WIDTH'(result + op_b) == op_a);
        assert_eq_zero_R8: assert (zero == (op_a == op_b));
      end
      if (op_sel == 3'b111) begin
        assert_slt_signed_R5: assert ((result[MSB:1] == '0)
                                      && (result[0] == ($signed(op_a) < $signed(op_b))));
      end
      if (op_sel[2] && sub_ovf) begin
        assert_ovf_signs_R6: assert (op_a[MSB] != op_b[MSB]);
      end
      if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101) begin
        assert_unused_clear_R9: assert (($countones(result) == 0) && zero);
      end
      if (zero) begin
        assert_zero_flag_R7: assert ($countones(result) == 0);
      end
    end
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .op_sel  (op_sel),
  .result  (result),
  .zero    (zero),
  .sub_ovf (sub_ovf)
);

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;

  localparam int SW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] a_big, b_big, r_big;
  logic [2:0]  sel_big;
  logic        z_big;
  logic [SW-1:0] a_sm, b_sm, r_sm;
  logic [2:0]    sel_sm;
  logic          z_sm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  alu_core #(.WIDTH(32), .GROUP(4)) u_dut (
    .op_a(a_big), .op_b(b_big), .op_sel(sel_big), .result(r_big), .zero(z_big)
  );

  alu_core #(.WIDTH(SW), .GROUP(2)) u_small (
    .op_a(a_sm), .op_b(b_sm), .op_sel(sel_sm), .result(r_sm), .zero(z_sm)
  );

  // Expected result from the requirements, for a given width.
  function automatic longint unsigned expect_res(int w, longint unsigned a,
                                                 longint unsigned b, int op);
    longint unsigned mask = (64'd1 << w) - 1;
    longint sa, sb;
    sa = ((a >> (w - 1)) & 1) != 0 ? longint'(a) - (longint'(1) << w) : longint'(a);
    sb = ((b >> (w - 1)) & 1) != 0 ? longint'(b) - (longint'(1) << w) : longint'(b);
    case (op)
      0: return a & b;                 // R1
      1: return a | b;                 // R2
      2: return (a + b) & mask;        // R3
      6: return (a - b) & mask;        // R4
      7: return (sa < sb) ? 1 : 0;     // R5
      default: return 0;               // R9
    endcase
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      6: return "R4";
      7: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, longint unsigned got, longint unsigned exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic run_big(logic [31:0] a, logic [31:0] b, int op, string tag);
    longint unsigned e;
    @(posedge clk);
    a_big = a; b_big = b; sel_big = 3'(op);
    @(negedge clk);
    e = expect_res(32, a, b, op);
    check(tag, r_big, e);
    check((op == 6) ? "R8" : "R7", z_big, (e == 0) ? 1 : 0);
  endtask

  initial begin
    a_big = '0; b_big = '0; sel_big = 3'b000;
    a_sm = '0; b_sm = '0; sel_sm = 3'b000;
    @(negedge clk);
    // Idle state with zero operands: AND gives zero, flag set (R7).
    check("R7", r_big, 0);
    check("R7", z_big, 1);

    // Exhaustive sweep of the small instance.
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < (1 << SW); a++) begin
        for (int b = 0; b < (1 << SW); b++) begin
          longint unsigned e;
          @(posedge clk);
          a_sm = SW'(a); b_sm = SW'(b); sel_sm = 3'(op);
          @(negedge clk);
          e = expect_res(SW, a, b, op);
          check(op_tag(op), r_sm, e);
          check((op == 6) ? "R8" : "R7", z_sm, (e == 0) ? 1 : 0);
        end
      end
    end

    // Range limits on the full-width instance (R6).
    run_big(32'h8000_0000, 32'h0000_0001, 7, "R6");
    run_big(32'h7FFF_FFFF, 32'hFFFF_FFFF, 7, "R6");
    run_big(32'h7FFF_FFFF, 32'h8000_0000, 7, "R6");
    run_big(32'h8000_0000, 32'h7FFF_FFFF, 7, "R6");
    run_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 7, "R5");
    run_big(32'h1234_5678, 32'h1234_5678, 6, "R8");
    run_big(32'h1234_5678, 32'h1234_5679, 6, "R8");
    run_big(32'hFFFF_FFFF, 32'h0000_0001, 2, "R3");
    run_big(32'hDEAD_BEEF, 32'hFFFF_FFFF, 3, "R9");
    run_big(32'hDEAD_BEEF, 32'hFFFF_FFFF, 4, "R9");
    run_big(32'hDEAD_BEEF, 32'hFFFF_FFFF, 5, "R9");

    // Pseudo-random operands on every code.
    begin
      logic [31:0] s = 32'h2545_F491;
      for (int n = 0; n < 200; n++) begin
        logic [31:0] ra, rb;
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); ra = s;
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); rb = s;
        for (int op = 0; op < 8; op++) begin
          run_big(ra, rb, op, op_tag(op));
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule